// File: doc/BRIEF.md
# Paired-Priority Edge Interrupt Controller

This block gathers eight interrupt request channels, arranged as four pairs (A, B, C, D, each with an even member 0 and an odd member 1), and presents one prioritized request to a processor core. Every channel has its own edge polarity select, a pending latch and a mask bit. Priority is programmed per pair: a 2-bit field per pair gives the upper two bits of a 3-bit level, and the channel's position in its pair gives the lowest bit. On most channels a select bit chooses whether the request comes from an external pin or from an on-chip peripheral line.

Software reaches the configuration through a small register port with a combinational read. The core sees the winning channel index, its level and a request flag. It returns an acknowledge with a channel index, which clears that channel's pending bit. Channel `c` belongs to pair `c/2`, and its member bit is `c%2`. Channel 0 is A0 and channel 7 is D1.

Register map (`cfg_addr`): 0 = edge select (bit c: 1 rising, 0 falling); 1 = pending (read state; a write of 0 to a bit clears it, a write of 1 does nothing); 2 = mask (1 = masked); 3 = pair priority (bits [2p+1:2p] are the field of pair p); 4 = source select (1 = pin, 0 = peripheral). Any other address reads 0.

Top module: `pairprio_irq_ctrl`

## Requirements
- R1: With edge select bit 1, a 0-to-1 change on the selected source sets the channel's pending bit on the third rising clock edge after the change. A 1-to-0 change does not set it.
- R2: With edge select bit 0, a 1-to-0 change sets the pending bit with the same latency. A 0-to-1 change does not set it.
- R3: A masked channel still latches and reports its pending bit, but it never drives `irq_req`. When no unmasked channel is pending, `irq_req`, `irq_chan` and `irq_level` are all 0.
- R4: The level of channel c is 2*field(pair c/2) + (c%2). It is reported on `irq_level` together with the channel on `irq_chan`.
- R5: Among the unmasked pending channels, the one with the numerically smallest level wins. On equal levels (when pairs share a field value), the smaller channel index wins. Within a pair, the even member beats the odd member.
- R6: `irq_ack` clears the pending bit of `irq_ack_chan`. A register write of 0 to a pending bit clears it, and a write of 1 leaves it unchanged.
- R7: A detected edge in the same cycle as a clear leaves the pending bit set.
- R8: Source select bit 1 routes the pin and bit 0 routes the peripheral line. Channels 6 and 7 have no peripheral and always use the pin, so their select bits read as 1 whatever is written.
- R9: After reset, edge select is 0x00, pending is 0x00, mask is 0xFF, priority is 0x00 and source select reads 0xC1 (only channel 0 takes its pin by default among the selectable ones).
- R10: Register reads return the stored values at the documented addresses, and 0 at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_req | input | 8 | External pin request per channel |
| per_req | input | 8 | Peripheral request per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | Acknowledge of a channel |
| irq_ack_chan | input | 3 | Channel being acknowledged |
| irq_req | output | 1 | Interrupt request to the core |
| irq_chan | output | 3 | Winning channel index |
| irq_level | output | 3 | Level of the winning channel (0 is highest) |

## Verification
The arbiter is swept over every one of the 256 priority-register values crossed with every one of the 256 mask patterns while all eight channels are pending. This shows whether the pair field and member bit are combined in the right order, whether shared field values are broken by index, and whether masking removes exactly the right candidates. Directed edge sequences drive each polarity in both directions, so a detector that fires on the wrong transition shows up. An acknowledge timed to land on the same edge as a new detection separates edge-over-clear from clear-over-edge. Source switching is tried with pin and peripheral lines disagreeing, which shows whether the select bit really gates the unselected line and whether the fixed-pin channels ignore the select.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int NPAIR = 4;
    localparam int NCH   = 2 * NPAIR;
    localparam int CHW   = $clog2(NCH);
    localparam int PFW   = 2;
    localparam int LW    = PFW + 1;
    localparam int NLVL  = 1 << LW;
    localparam int DW    = NCH;
    localparam int AW    = 3;

    typedef enum logic [AW-1:0] {
        ADR_EDGE = 3'd0,
        ADR_PEND = 3'd1,
        ADR_MASK = 3'd2,
        ADR_PRIO = 3'd3,
        ADR_SRC  = 3'd4
    } cfg_adr_e;

    function automatic logic [LW-1:0] chan_level(input logic [NPAIR*PFW-1:0] prio,
                                                input int ch);
        logic [PFW-1:0] fld;
        fld = prio[(ch/2)*PFW +: PFW];
        return {fld, logic'(ch % 2)};
    endfunction
endpackage

// File: rtl/pirq_chan.sv
module pirq_chan #(
    parameter bit HAS_SEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic per,
    input  logic use_pin,
    input  logic rise_sel,
    input  logic clr,
    output logic pend
);
    logic src, sync1, sync2, dly, hit;

    generate
        if (HAS_SEL) begin : g_sel
            assign src = use_pin ? pin : per;
        end else begin : g_pin
            logic unused_in;
            assign unused_in = per ^ use_pin;
            assign src = pin;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            dly   <= 1'b0;
        end else begin
            sync1 <= src;
            sync2 <= sync1;
            dly   <= sync2;
        end
    end

    assign hit = rise_sel ? (sync2 & ~dly) : (~sync2 & dly);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pend <= 1'b0;
        else if (hit) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end
endmodule

// File: rtl/pirq_regfile.sv
module pirq_regfile
    import pirq_pkg::*;
#(
    parameter logic [NCH-1:0] SEL_CAP = 8'h3F,
    parameter logic [NCH-1:0] SRC_RST = 8'h01
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic [NCH-1:0]         pend,
    output logic [NCH-1:0]         rise_sel,
    output logic [NCH-1:0]         mask,
    output logic [NPAIR*PFW-1:0]   prio,
    output logic [NCH-1:0]         use_pin,
    output logic [NCH-1:0]         sw_clr,
    output logic [DW-1:0]          rdata
);
    logic [NCH-1:0] src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_sel <= '0;
            mask     <= '1;
            prio     <= '0;
            src_q    <= SRC_RST & SEL_CAP;
        end else if (we) begin
            case (addr)
                ADR_EDGE: rise_sel <= wdata;
                ADR_MASK: mask     <= wdata;
                ADR_PRIO: prio     <= wdata;
                ADR_SRC:  src_q    <= wdata & SEL_CAP;
                default: ;
            endcase
        end
    end

    assign use_pin = src_q | ~SEL_CAP;
    assign sw_clr  = (we && addr == ADR_PEND) ? ~wdata : '0;

    always_comb begin
        case (addr)
            ADR_EDGE: rdata = rise_sel;
            ADR_PEND: rdata = pend;
            ADR_MASK: rdata = mask;
            ADR_PRIO: rdata = prio;
            ADR_SRC:  rdata = use_pin;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter
    import pirq_pkg::*;
(
    input  logic [NCH-1:0]       active,
    input  logic [NPAIR*PFW-1:0] prio,
    output logic                 req,
    output logic [CHW-1:0]       chan,
    output logic [LW-1:0]        level
);
    always_comb begin
        req   = 1'b0;
        chan  = '0;
        level = '0;
        for (int lv = 0; lv < NLVL; lv++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (!req && active[ch] && chan_level(prio, ch) == LW'(lv)) begin
                    req   = 1'b1;
                    chan  = CHW'(ch);
                    level = LW'(lv);
                end
            end
        end
    end
endmodule

// File: rtl/pairprio_irq_ctrl.sv
module pairprio_irq_ctrl
    import pirq_pkg::*;
#(
    parameter logic [NCH-1:0] SEL_CAP = 8'h3F,
    parameter logic [NCH-1:0] SRC_RST = 8'h01
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_req,
    input  logic [NCH-1:0] per_req,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    input  logic           irq_ack,
    input  logic [CHW-1:0] irq_ack_chan,
    output logic           irq_req,
    output logic [CHW-1:0] irq_chan,
    output logic [LW-1:0]  irq_level
);
    logic [NCH-1:0]       rise_sel, mask_q, use_pin, sw_clr, ack_clr, pend_q;
    logic [NPAIR*PFW-1:0] prio_q;

    pirq_regfile #(.SEL_CAP(SEL_CAP), .SRC_RST(SRC_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .pend(pend_q), .rise_sel(rise_sel),
        .mask(mask_q), .prio(prio_q), .use_pin(use_pin),
        .sw_clr(sw_clr), .rdata(cfg_rdata)
    );

    assign ack_clr = irq_ack ? (NCH'(1) << irq_ack_chan) : '0;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            pirq_chan #(.HAS_SEL(SEL_CAP[c])) u_ch (
                .clk(clk), .rst_n(rst_n), .pin(pin_req[c]), .per(per_req[c]),
                .use_pin(use_pin[c]), .rise_sel(rise_sel[c]),
                .clr(sw_clr[c] | ack_clr[c]), .pend(pend_q[c])
            );
        end
    endgenerate

    pirq_arbiter u_arb (
        .active(pend_q & ~mask_q), .prio(prio_q),
        .req(irq_req), .chan(irq_chan), .level(irq_level)
    );
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk
    import pirq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       pend,
    input logic [NCH-1:0]       mask,
    input logic [NPAIR*PFW-1:0] prio,
    input logic                 irq_req,
    input logic [CHW-1:0]       irq_chan,
    input logic [LW-1:0]        irq_level
);
    function automatic logic beaten(input logic [NCH-1:0] act,
                                    input logic [NPAIR*PFW-1:0] pr,
                                    input logic [CHW-1:0] win);
        logic b;
        int wl, l;
        b  = 1'b0;
        wl = 2 * int'(pr[int'(win)/2*PFW +: PFW]) + int'(win) % 2;
        for (int c = 0; c < NCH; c++) begin
            l = 2 * int'(pr[c/2*PFW +: PFW]) + c % 2;
            if (act[c] && (l < wl || (l == wl && c < int'(win)))) b = 1'b1;
        end
        return b;
    endfunction

    // R3
    win_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend[irq_chan] && !mask[irq_chan]));

    // R3
    idle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> ((pend & ~mask) == '0 && irq_chan == '0 && irq_level == '0));

    // R4
    level_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level[0] == irq_chan[0] &&
                     irq_level[LW-1:1] == prio[int'(irq_chan)/2*PFW +: PFW]));

    // R5
    no_better_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !beaten(pend & ~mask, prio, irq_chan));
endmodule

bind pairprio_irq_ctrl pirq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .mask(mask_q), .prio(prio_q),
    .irq_req(irq_req), .irq_chan(irq_chan), .irq_level(irq_level)
);

// File: tb/sim_pairprio_irq_ctrl.sv
module sim_pairprio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_req = '0, per_req = '0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       irq_ack = 1'b0;
    logic [2:0] irq_ack_chan = '0;
    logic       irq_req;
    logic [2:0] irq_chan, irq_level;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pairprio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_req(pin_req), .per_req(per_req),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_ack(irq_ack), .irq_ack_chan(irq_ack_chan),
        .irq_req(irq_req), .irq_chan(irq_chan), .irq_level(irq_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [6:0] model(input logic [7:0] prio, input logic [7:0] act);
        int bl, bc, l;
        bl = 8; bc = 0;
        for (int c = 0; c < 8; c++) begin
            l = 2 * ((prio >> (2 * (c / 2))) & 3) + (c & 1);
            if (act[c] && l < bl) begin bl = l; bc = c; end
        end
        if (bl == 8) return 7'd0;
        return {1'b1, 3'(bc), 3'(bl)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd(3'd0, d); check("R9 edge", d, 8'h00);
        rd(3'd1, d); check("R9 pend", d, 8'h00);
        rd(3'd2, d); check("R9 mask", d, 8'hFF);
        rd(3'd3, d); check("R9 prio", d, 8'h00);
        rd(3'd4, d); check("R9 R8 src", d, 8'hC1);
        check("R9 irq idle", {irq_req, irq_chan, irq_level}, 7'd0);
        // R10 unused address
        rd(3'd5, d); check("R10 unused", d, 8'h00);

        // R2 falling edge on channel 0 (pin, edge select 0)
        pin_req[0] = 1'b1; settle();
        rd(3'd1, d); check("R2 rise ignored", d, 8'h00);
        pin_req[0] = 1'b0; settle();
        rd(3'd1, d); check("R2 fall sets", d, 8'h01);
        // R3 masked: pending but no request
        check("R3 masked", irq_req, 1'b0);
        wr(3'd2, 8'hFE);
        check("R3 R4 unmasked", {irq_req, irq_chan, irq_level}, {1'b1, 3'd0, 3'd0});
        // R6 ack clears
        irq_ack = 1'b1; irq_ack_chan = 3'd0;
        @(posedge clk); @(negedge clk); irq_ack = 1'b0;
        rd(3'd1, d); check("R6 ack", d, 8'h00);
        check("R6 req gone", irq_req, 1'b0);

        // R1 rising on channel 0; R6 software write
        wr(3'd0, 8'h01);
        pin_req[0] = 1'b1; settle();
        rd(3'd1, d); check("R1 rise sets", d, 8'h01);
        wr(3'd1, 8'hFF);
        rd(3'd1, d); check("R6 write 1 keeps", d, 8'h01);
        wr(3'd1, 8'hFE);
        rd(3'd1, d); check("R6 write 0 clears", d, 8'h00);
        pin_req[0] = 1'b0; settle();
        rd(3'd1, d); check("R1 fall ignored", d, 8'h00);

        // R7 edge coinciding with ack on channel 1 (peripheral source)
        wr(3'd0, 8'h03);
        per_req[1] = 1'b1; settle();
        rd(3'd1, d); check("R8 per ch1", d, 8'h02);
        per_req[1] = 1'b0; settle();
        per_req[1] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b1; irq_ack_chan = 3'd1;
        @(posedge clk); @(negedge clk); irq_ack = 1'b0;
        rd(3'd1, d); check("R7 edge wins", d, 8'h02);
        irq_ack = 1'b1;
        @(posedge clk); @(negedge clk); irq_ack = 1'b0;
        rd(3'd1, d); check("R7 ack alone", d, 8'h00);

        // R8 source switching on channel 2
        wr(3'd0, 8'h07);
        pin_req[2] = 1'b1; settle();
        rd(3'd1, d); check("R8 pin gated", d, 8'h00);
        per_req[2] = 1'b1; settle();
        rd(3'd1, d); check("R8 per routed", d, 8'h04);
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h05); settle();
        rd(3'd1, d); check("R8 switch no edge", d, 8'h00);
        per_req[2] = 1'b0; settle();
        per_req[2] = 1'b1; settle();
        rd(3'd1, d); check("R8 per gated", d, 8'h00);
        pin_req[2] = 1'b0; settle();
        pin_req[2] = 1'b1; settle();
        rd(3'd1, d); check("R8 pin routed", d, 8'h04);
        wr(3'd4, 8'h00);
        rd(3'd4, d); check("R8 fixed pins", d, 8'hC0);
        rd(3'd0, d); check("R10 edge readback", d, 8'h07);

        // R5 R4 sweep: all pending, every prio x every mask
        wr(3'd4, 8'hFF);
        wr(3'd0, 8'hFF);
        pin_req = 8'h00; per_req = 8'h00; settle();
        wr(3'd1, 8'h00);
        pin_req = 8'hFF; settle();
        rd(3'd1, d); check("R1 all rise", d, 8'hFF);
        for (int p = 0; p < 256; p++) begin
            wr(3'd3, 8'(p));
            for (int m = 0; m < 256; m++) begin
                wr(3'd2, 8'(m));
                check("R5 R4 sweep", {irq_req, irq_chan, irq_level}, model(8'(p), ~8'(m)));
            end
        end
        rd(3'd3, d); check("R10 prio readback", d, 8'hFF);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule